// File: doc/BRIEF.md
# Four-Bank Word-Interleaved Line-Fill Memory

This block is a main-memory model with its controller. It serves cache-line fills and single-word accesses from four word-interleaved banks. The low two bits of a word address choose the bank, and the remaining bits choose the row inside that bank. A line fill sends one line address to all four banks in a single cycle. All four banks then run their fixed-latency access side by side. The four words come back over a one-word return bus on four consecutive cycles, in word order.

Single-word reads and writes occupy only their own bank. Several of them can therefore be in flight at once when they target different banks. A requester holds `req_valid` with its fields stable until it sees `req_ready` high at a clock edge. `req_ready` depends only on the request type, the target bank and the bank states, and never on `req_valid`.

Each bank is a small state machine with four states:
- `BK_IDLE` moves to `BK_ADDR` on *start*.
- `BK_ADDR` lasts one cycle for address transfer and moves to `BK_ACCESS`.
- `BK_ACCESS` lasts LAT cycles (default 15). On *done*, a write commits to the array and returns to `BK_IDLE`, while a read latches its word and moves to `BK_HOLD`.
- `BK_HOLD` waits its return slot, counting down, and returns to `BK_IDLE` on *send*.

A line read loads bank k with slot k. A single read loads slot 0.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: After reset, `rsp_valid` is low and every bank is idle, so `req_ready` is high for any request type.
- R2: Word address `a` is held in bank `a[1:0]` at row `a[ADDR_W-1:2]`. A single read of `a` returns the word last written to `a`, with `rsp_idx` equal to `a[1:0]`.
- R3: A line read returns the four words of the addressed line in order, `rsp_idx` 0, 1, 2, 3. `rsp_last` is set only on index 3, and word k is the data at address `{line, k}`.
- R4: When a line read is accepted at edge E, word k appears on the return bus after edge E+17+k. The last word therefore appears 20 cycles after acceptance, counted as 1 address cycle, 15 access cycles and 4 bus cycles.
- R5: When a single read is accepted at edge E, it returns exactly one word after edge E+17 with `rsp_last`=1. Its bank accepts a new request at edge E+18 at the earliest.
- R6: A single write (`req_we`=1, `req_line`=0) returns no response. It keeps its bank busy through edge E+16, and a later read of that address returns the new data.
- R7: Single requests to different idle banks are accepted on consecutive cycles and run overlapped.
- R8: `req_ready` is low while a single request's target bank is busy, or while a line request finds any bank busy. The request is taken at the first edge after the blocking bank frees.
- R9: For a line request the low two address bits and `req_we` are ignored. The line is read from word 0, and memory is left unchanged.
- R10: `rsp_valid` is high only in the cycles where a word is due under R4 or R5, and at most one word is presented per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_line | input | 1 | 1 = four-word line read, 0 = single word |
| req_we | input | 1 | Single-word write when `req_line`=0 |
| req_addr | input | ADDR_W | Word address; low two bits select the bank |
| req_wdata | input | DATA_W | Write data for single writes |
| rsp_valid | output | 1 | Return word valid |
| rsp_data | output | DATA_W | Return word |
| rsp_idx | output | 2 | Word index within the line, which equals the bank number |
| rsp_last | output | 1 | Final word of this request |

## Verification
Every return word is due a fixed number of edges after the edge that accepts its request. For a line, word k is due at edge E+17+k. A single read is due at E+17. A write frees its bank at E+16 and a read frees its bank at E+17. The reference model in the bench stamps each expected word with its due edge number and predicts `req_ready` from per-bank busy-until edges. It compares `req_ready` before each edge and the return bus after each edge, so a word one cycle early or late fails as both a missing word and a spurious one. Dedicated checks measure the 20-cycle line latency, the back-to-back acceptance of requests to different banks, and the 18-edge stall behind a busy bank.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    localparam int NUM_BANKS = 4;
    localparam int SEL_W     = $clog2(NUM_BANKS);

    typedef enum logic [1:0] {
        BK_IDLE,
        BK_ADDR,
        BK_ACCESS,
        BK_HOLD
    } bank_state_e;
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank
    import ilv_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ROW_W  = 6,
    parameter int LAT    = 15,
    parameter int SLOT   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_line,
    input  logic              start_we,
    input  logic [ROW_W-1:0]  start_row,
    input  logic [DATA_W-1:0] start_wdata,
    output logic              idle,
    output logic              send,
    output logic              line_mode,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ROW_W;
    localparam int CNT_W = $clog2(LAT + 1);

    bank_state_e        state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [SEL_W-1:0]   slot_q, slot_d;
    logic [ROW_W-1:0]   row_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [DATA_W-1:0]  data_q;
    logic               we_q;
    logic               line_q;
    logic               done;
    logic [DATA_W-1:0]  mem [DEPTH];

    assign done = (state_q == BK_ACCESS) && (cnt_q == CNT_W'(LAT - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        slot_d  = slot_q;
        unique case (state_q)
            BK_IDLE: begin
                if (start) state_d = BK_ADDR;
            end
            BK_ADDR: begin
                state_d = BK_ACCESS;
                cnt_d   = '0;
            end
            BK_ACCESS: begin
                if (done) begin
                    state_d = we_q ? BK_IDLE : BK_HOLD;
                    slot_d  = line_q ? SEL_W'(SLOT) : '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            BK_HOLD: begin
                if (slot_q == '0) state_d = BK_IDLE;
                else              slot_d  = slot_q - 1'b1;
            end
            default: state_d = BK_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BK_IDLE;
            cnt_q   <= '0;
            slot_q  <= '0;
            row_q   <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            line_q  <= 1'b0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            slot_q  <= slot_d;
            if (start && state_q == BK_IDLE) begin
                row_q   <= start_row;
                wdata_q <= start_wdata;
                we_q    <= start_we;
                line_q  <= start_line;
            end
            if (done && !we_q) data_q <= mem[row_q];
        end
    end

    always_ff @(posedge clk) begin
        if (done && we_q) mem[row_q] <= wdata_q;
    end

    // outputs
    always_comb begin
        idle      = (state_q == BK_IDLE);
        send      = (state_q == BK_HOLD) && (slot_q == '0);
        line_mode = line_q;
        rd_data   = data_q;
    end
endmodule

// File: rtl/ilv_rsp_port.sv
module ilv_rsp_port
    import ilv_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_BANKS-1:0]              bank_send,
    input  logic [NUM_BANKS-1:0]              bank_line,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0]  bank_data,
    output logic                              rsp_valid,
    output logic [DATA_W-1:0]                 rsp_data,
    output logic [SEL_W-1:0]                  rsp_idx,
    output logic                              rsp_last
);
    logic             hit;
    logic [SEL_W-1:0] sel;

    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_send[b]) begin
                hit = 1'b1;
                sel = SEL_W'(b);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_idx   <= '0;
            rsp_last  <= 1'b0;
        end else begin
            rsp_valid <= hit;
            rsp_data  <= bank_data[sel];
            rsp_idx   <= sel;
            rsp_last  <= hit && (!bank_line[sel] || sel == SEL_W'(NUM_BANKS - 1));
        end
    end
endmodule

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl
    import ilv_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int LAT    = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_line,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [1:0]        rsp_idx,
    output logic              rsp_last
);
    localparam int ROW_W = ADDR_W - SEL_W;

    logic [NUM_BANKS-1:0]             bank_idle;
    logic [NUM_BANKS-1:0]             bank_send;
    logic [NUM_BANKS-1:0]             bank_line;
    logic [NUM_BANKS-1:0]             bank_start;
    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_data;
    logic [SEL_W-1:0]                 tgt;
    logic                             accept;

    assign tgt       = req_addr[SEL_W-1:0];
    assign req_ready = req_line ? (&bank_idle) : bank_idle[tgt];
    assign accept    = req_valid && req_ready;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_start[b] = accept && (req_line || tgt == SEL_W'(b));

        ilv_bank #(
            .DATA_W (DATA_W),
            .ROW_W  (ROW_W),
            .LAT    (LAT),
            .SLOT   (b)
        ) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .start       (bank_start[b]),
            .start_line  (req_line),
            .start_we    (req_we && !req_line),
            .start_row   (req_addr[ADDR_W-1:SEL_W]),
            .start_wdata (req_wdata),
            .idle        (bank_idle[b]),
            .send        (bank_send[b]),
            .line_mode   (bank_line[b]),
            .rd_data     (bank_data[b])
        );
    end

    ilv_rsp_port #(
        .DATA_W (DATA_W)
    ) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .bank_send (bank_send),
        .bank_line (bank_line),
        .bank_data (bank_data),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_idx   (rsp_idx),
        .rsp_last  (rsp_last)
    );
endmodule

// File: rtl/ilv_mem_ctrl_chk.sv
module ilv_mem_ctrl_chk
    import ilv_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 req_line,
    input logic [ADDR_W-1:0]    req_addr,
    input logic                 rsp_valid,
    input logic [1:0]           rsp_idx,
    input logic                 rsp_last,
    input logic [NUM_BANKS-1:0] bank_idle,
    input logic [NUM_BANKS-1:0] bank_send
);
    // R3: a line is only started when every bank is idle
    a_r3_line_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_line |-> &bank_idle);

    // R3: a non-final word is followed directly by the next index
    a_r3_idx_seq: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_last |=> rsp_valid && rsp_idx == $past(rsp_idx) + 2'd1);

    // R7: an accepted single request makes its bank busy next cycle
    a_r7_bank_taken: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_line |=> !bank_idle[$past(req_addr[SEL_W-1:0])]);

    // R10: at most one bank offers a word per cycle
    a_r10_one_sender: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_send));

    // R10: a returned word was offered by a bank in the previous cycle
    a_r10_valid_from_bank: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(|bank_send));
endmodule

bind ilv_mem_ctrl ilv_mem_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_ilv_mem_ctrl.sv
module sim_ilv_mem_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_line = 1'b0;
    logic        req_we = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic [1:0]  rsp_idx;
    logic        rsp_last;

    always #10 clk = ~clk;

    ilv_mem_ctrl u0 (.*);

    typedef struct {
        int          due;
        logic [31:0] d;
        logic [1:0]  idx;
        logic        last;
    } exp_t;

    exp_t        q[$];
    logic [31:0] ref_mem [256];
    int          busy_until [4];
    int          ecount = 0;
    int          nchk = 0;
    int          nfail = 0;
    int          last_edge = -1;
    string       cur_tag = "R10";
    bit          done = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h (edge %0d)", tag, act, exp, ecount);
        end
    endtask

    task automatic check_rsp();
        if (q.size() > 0 && q[0].due == ecount) begin
            chk(rsp_valid == 1'b1, "R4", 64'(rsp_valid), 64'd1);
            chk(rsp_data == q[0].d, cur_tag, 64'(rsp_data), 64'(q[0].d));
            chk(rsp_idx == q[0].idx, "R3", 64'(rsp_idx), 64'(q[0].idx));
            chk(rsp_last == q[0].last, "R3", 64'(rsp_last), 64'(q[0].last));
            if (q[0].last) last_edge = ecount;
            void'(q.pop_front());
        end else begin
            chk(rsp_valid == 1'b0, "R10", 64'(rsp_valid), 64'd0);
        end
    endtask

    // one clock cycle: drive, check ready, take edge, update model, check return bus
    task automatic tick(input bit v, input bit ln, input bit we, input logic [7:0] a,
                        input logic [31:0] wd, output bit acc);
        bit exp_rdy;
        req_valid = v; req_line = ln; req_we = we; req_addr = a; req_wdata = wd;
        #1;
        if (ln) begin
            exp_rdy = 1'b1;
            for (int k = 0; k < 4; k++) if (busy_until[k] >= ecount + 1) exp_rdy = 1'b0;
        end else begin
            exp_rdy = busy_until[a[1:0]] < ecount + 1;
        end
        chk(req_ready == exp_rdy, "R8", 64'(req_ready), 64'(exp_rdy));
        acc = v && exp_rdy;
        @(posedge clk);
        ecount++;
        if (acc) begin
            if (ln) begin
                for (int k = 0; k < 4; k++) begin
                    busy_until[k] = ecount + 17 + k;
                    q.push_back('{ecount + 17 + k, ref_mem[{a[7:2], 2'(k)}], 2'(k), k == 3});
                end
            end else if (we) begin
                busy_until[a[1:0]] = ecount + 16;
                ref_mem[a] = wd;
            end else begin
                busy_until[a[1:0]] = ecount + 17;
                q.push_back('{ecount + 17, ref_mem[a], a[1:0], 1'b1});
            end
        end
        @(negedge clk);
        check_rsp();
    endtask

    task automatic issue(input bit ln, input bit we, input logic [7:0] a,
                         input logic [31:0] wd, output int e);
        bit acc = 0;
        while (!acc) tick(1'b1, ln, we, a, wd, acc);
        e = ecount;
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        bit acc;
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1'b0, 8'h00, 32'h0, acc);
    endtask

    task automatic drain();
        while (q.size() > 0) idle(1);
        idle(3);
    endtask

    initial begin
        int e1, e2;
        for (int b = 0; b < 4; b++) busy_until[b] = -1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(rsp_valid == 1'b0, "R1", 64'(rsp_valid), 64'd0);
        req_line = 1'b1;
        #1;
        chk(req_ready == 1'b1, "R1", 64'(req_ready), 64'd1);
        req_line = 1'b0;
        @(negedge clk);

        // R6: fill all of memory with single writes spread over the banks
        cur_tag = "R6";
        for (int a = 0; a < 256; a++)
            issue(1'b0, 1'b1, 8'(a), 32'hC0DE0000 ^ (32'(a) * 32'h00010203), e1);
        idle(20);

        // R4: line latency and order
        cur_tag = "R3";
        issue(1'b1, 1'b0, 8'h14, 32'h0, e1);
        drain();
        chk(last_edge - e1 == 20, "R4", 64'(last_edge - e1), 64'd20);

        // R9: line with low bits set and write flag set reads from word 0, leaves memory
        cur_tag = "R9";
        issue(1'b1, 1'b1, 8'h23, 32'hDEADBEEF, e1);
        drain();
        issue(1'b1, 1'b0, 8'h20, 32'h0, e1);
        drain();

        // R2: single read returns mapped word and index
        cur_tag = "R2";
        issue(1'b0, 1'b0, 8'h1E, 32'h0, e1);
        drain();

        // R7: overlap of singles to different banks
        cur_tag = "R7";
        issue(1'b0, 1'b0, 8'h40, 32'h0, e1);
        issue(1'b0, 1'b0, 8'h41, 32'h0, e2);
        chk(e2 == e1 + 1, "R7", 64'(e2 - e1), 64'd1);
        drain();

        // R8: same-bank stall, then line stalled by one busy bank
        cur_tag = "R8";
        issue(1'b0, 1'b0, 8'h46, 32'h0, e1);
        issue(1'b0, 1'b0, 8'h4A, 32'h0, e2);
        chk(e2 == e1 + 18, "R8", 64'(e2 - e1), 64'd18);
        drain();
        issue(1'b0, 1'b0, 8'h51, 32'h0, e1);
        issue(1'b1, 1'b0, 8'h60, 32'h0, e2);
        chk(e2 == e1 + 18, "R8", 64'(e2 - e1), 64'd18);
        drain();

        // R6: write then read back the new data
        cur_tag = "R6";
        issue(1'b0, 1'b1, 8'h33, 32'h5A5A1234, e1);
        issue(1'b0, 1'b0, 8'h33, 32'h0, e2);
        chk(e2 == e1 + 17, "R6", 64'(e2 - e1), 64'd17);
        drain();

        // R5: single read right after a line into bank 0
        cur_tag = "R5";
        issue(1'b1, 1'b0, 8'h74, 32'h0, e1);
        issue(1'b0, 1'b0, 8'h80, 32'h0, e2);
        chk(e2 == e1 + 18, "R5", 64'(e2 - e1), 64'd18);
        drain();
        chk(last_edge == e2 + 17, "R5", 64'(last_edge - e2), 64'd17);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule